// File: doc/BRIEF.md
# Two-Port Bidirectional Pin Controller

This block controls the pins of two general-purpose I/O ports: a 4-bit narrow port and an 8-bit wide port. Each port has two registers. One is an output latch that a bus write to the port's address loads. The other is a direction register. The processor cannot write the direction register over the bus. It is loaded from the processor's working value only by a separate direction-load command that names the port. A direction bit of 1 leaves its pin undriven (input). A direction bit of 0 drives the latched bit onto the pin. The block presents per-pin output-enable and output-data signals to the pad ring.

A bus read of a port address returns the level actually present on the pins, not the latch contents. The pins are passed through a two-stage synchronizer, so a read sees the pin level from two clocks earlier. The narrow port is mapped at address 05h and the wide port at 06h. For the narrow port, bits 7:4 of read data are zero.

There are two resets. Both make every pin an input by setting all direction bits. A power-on reset also loads the latches with a parameter value. A warm reset leaves the latches as they were, so the first direction load after a warm reset drives the values written before it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A pin's output enable is the inverse of its direction bit, and its output data is its latch bit. Both change on the clock edge that captures the write, so the new value appears one clock after the write is presented.
- R2: When either power_on_rst or warm_rst is sampled high, every direction bit of both ports becomes 1. All output enables are then low.
- R3: Direction bits change only on a dir_load cycle. With dir_sel=0 the narrow port takes work_reg[3:0]; with dir_sel=1 the wide port takes work_reg[7:0]. Bus writes to any address leave the direction bits unchanged.
- R4: The read data at address 05h or 06h is that port's pin input level, delayed by two clocks. It is never the latch value. A pin that is driven high but held low externally reads 0.
- R5: A bus write (bus_wr=1) to address 05h loads the narrow latch, and a write to 06h loads the wide latch. A latch keeps its value until its own address is written again. Writes to other addresses have no effect on either latch.
- R6: The narrow port keeps only bits 3:0. Read data bits 7:4 are 0 at address 05h, and bits 7:4 of a write to 05h are discarded.
- R7: A power-on reset loads the narrow latch with LATCH_POR_VAL[3:0] and the wide latch with LATCH_POR_VAL[7:0].
- R8: A warm reset leaves both latches unchanged.
- R9: A read at any address other than 05h or 06h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| power_on_rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe for the port latches |
| bus_wdata | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data: synchronized pin levels |
| dir_load | input | 1 | Direction-load command |
| dir_sel | input | 1 | Port selected by the command: 0 = narrow, 1 = wide |
| work_reg | input | 8 | Working value loaded into the selected direction register |
| pin_in_a | input | 4 | Narrow port pin levels |
| pin_in_b | input | 8 | Wide port pin levels |
| pad_oe_a | output | 4 | Narrow port output enables |
| pad_out_a | output | 4 | Narrow port output data |
| pad_oe_b | output | 8 | Wide port output enables |
| pad_out_b | output | 8 | Wide port output data |

## Verification
Some rules are checked by assertions on every cycle:
- every direction bit is set after either reset;
- direction bits never move without a direction-load command;
- latches never move without a write to their address, and they survive a warm reset;
- the upper nibble of a narrow-port read is zero.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference model:
- that reads return the pins and not the latch, including a pin held low while driven high;
- the two-clock read latency;
- the power-on latch value;
- that writes to foreign addresses leave the pad outputs untouched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BUS_W = 8;

    typedef enum logic {
        SEL_NARROW = 1'b0,
        SEL_WIDE   = 1'b1
    } port_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:0] POR_VAL = '0
) (
    input  logic         clk,
    input  logic         power_on_rst,
    input  logic         warm_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         dir_ld,
    input  logic [W-1:0] dir_val,
    output logic [W-1:0] oe,
    output logic [W-1:0] dout
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    // Output latch: power-on loads POR_VAL, warm reset keeps the contents
    always_ff @(posedge clk) begin
        if (power_on_rst) begin
            latch_q <= POR_VAL;
        end else if (wr_en) begin
            latch_q <= wdata;
        end
    end

    // Direction register: forced to all inputs on either reset
    always_ff @(posedge clk) begin
        if (power_on_rst || warm_rst) begin
            dir_q <= '1;
        end else if (dir_ld) begin
            dir_q <= dir_val;
        end
    end

    assign oe   = ~dir_q;
    assign dout = latch_q;

    // R2
    dir_reset_chk: assert property (@(posedge clk)
        (power_on_rst || warm_rst) |=> (dir_q == '1));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (power_on_rst || warm_rst)
        !dir_ld |=> $stable(dir_q));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (power_on_rst)
        (!wr_en && !warm_rst) |=> $stable(latch_q));

    // R8
    warm_keep_chk: assert property (@(posedge clk) disable iff (power_on_rst)
        warm_rst |=> $stable(latch_q));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int               NARROW_W      = 4,
    parameter int               WIDE_W        = 8,
    parameter logic [BUS_W-1:0] NARROW_ADDR   = 8'h05,
    parameter logic [BUS_W-1:0] WIDE_ADDR     = 8'h06,
    parameter logic [BUS_W-1:0] LATCH_POR_VAL = 8'hA5
) (
    input  logic                clk,
    input  logic                power_on_rst,
    input  logic                warm_rst,
    input  logic [BUS_W-1:0]    bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rd_data,
    input  logic                dir_load,
    input  logic                dir_sel,
    input  logic [BUS_W-1:0]    work_reg,
    input  logic [NARROW_W-1:0] pin_in_a,
    input  logic [WIDE_W-1:0]   pin_in_b,
    output logic [NARROW_W-1:0] pad_oe_a,
    output logic [NARROW_W-1:0] pad_out_a,
    output logic [WIDE_W-1:0]   pad_oe_b,
    output logic [WIDE_W-1:0]   pad_out_b
);
    localparam int PAD_A = BUS_W - NARROW_W;
    localparam int PAD_B = BUS_W - WIDE_W;

    logic                any_rst;
    logic                wr_a, wr_b, ld_a, ld_b;
    logic [NARROW_W-1:0] sync_a;
    logic [WIDE_W-1:0]   sync_b;
    port_sel_e           sel;

    assign any_rst = power_on_rst || warm_rst;
    assign sel     = port_sel_e'(dir_sel);
    assign wr_a    = bus_wr && (bus_addr == NARROW_ADDR);
    assign wr_b    = bus_wr && (bus_addr == WIDE_ADDR);
    assign ld_a    = dir_load && (sel == SEL_NARROW);
    assign ld_b    = dir_load && (sel == SEL_WIDE);

    gpio_port_reg #(.W(NARROW_W), .POR_VAL(LATCH_POR_VAL[NARROW_W-1:0])) u_port_a (
        .clk(clk), .power_on_rst(power_on_rst), .warm_rst(warm_rst),
        .wr_en(wr_a), .wdata(bus_wdata[NARROW_W-1:0]),
        .dir_ld(ld_a), .dir_val(work_reg[NARROW_W-1:0]),
        .oe(pad_oe_a), .dout(pad_out_a)
    );

    gpio_port_reg #(.W(WIDE_W), .POR_VAL(LATCH_POR_VAL[WIDE_W-1:0])) u_port_b (
        .clk(clk), .power_on_rst(power_on_rst), .warm_rst(warm_rst),
        .wr_en(wr_b), .wdata(bus_wdata[WIDE_W-1:0]),
        .dir_ld(ld_b), .dir_val(work_reg[WIDE_W-1:0]),
        .oe(pad_oe_b), .dout(pad_out_b)
    );

    gpio_sync #(.W(NARROW_W)) u_sync_a (.clk(clk), .rst(any_rst), .d(pin_in_a), .q(sync_a));
    gpio_sync #(.W(WIDE_W))   u_sync_b (.clk(clk), .rst(any_rst), .d(pin_in_b), .q(sync_b));

    // Read path: zero-extend each port's synchronized pins to the bus width
    logic [BUS_W-1:0] ext_a, ext_b;
    generate
        if (PAD_A > 0) begin : g_ext_a
            assign ext_a = {{PAD_A{1'b0}}, sync_a};
        end else begin : g_full_a
            assign ext_a = sync_a;
        end
        if (PAD_B > 0) begin : g_ext_b
            assign ext_b = {{PAD_B{1'b0}}, sync_b};
        end else begin : g_full_b
            assign ext_b = sync_b;
        end
    endgenerate

    always_comb begin
        if (bus_addr == NARROW_ADDR) begin
            bus_rd_data = ext_a;
        end else if (bus_addr == WIDE_ADDR) begin
            bus_rd_data = ext_b;
        end else begin
            bus_rd_data = '0;
        end
    end

    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk)
        (bus_addr == NARROW_ADDR) |-> (bus_rd_data[BUS_W-1:NARROW_W] == '0));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;
    logic       clk = 1'b0;
    logic       power_on_rst, warm_rst, bus_wr, dir_load, dir_sel;
    logic [7:0] bus_addr, bus_wdata, work_reg, bus_rd_data, pin_in_b;
    logic [3:0] pin_in_a, pad_oe_a, pad_out_a;
    logic [7:0] pad_oe_b, pad_out_b;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [3:0] m_lat_a, m_dir_a;
    logic [7:0] m_lat_b, m_dir_b;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .power_on_rst(power_on_rst), .warm_rst(warm_rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd_data(bus_rd_data), .dir_load(dir_load), .dir_sel(dir_sel),
        .work_reg(work_reg), .pin_in_a(pin_in_a), .pin_in_b(pin_in_b),
        .pad_oe_a(pad_oe_a), .pad_out_a(pad_out_a),
        .pad_oe_b(pad_oe_b), .pad_out_b(pad_out_b)
    );

    function automatic logic [7:0] exp_oe_b();
        return ~m_dir_b;
    endfunction

    function automatic logic [3:0] exp_oe_a();
        return ~m_dir_a;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_pads(input string req);
        chk({req, " oe_a"}, {4'h0, pad_oe_a}, {4'h0, exp_oe_a()});
        chk({req, " out_a"}, {4'h0, pad_out_a}, {4'h0, m_lat_a});
        chk({req, " oe_b"}, pad_oe_b, exp_oe_b());
        chk({req, " out_b"}, pad_out_b, m_lat_b);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h05) m_lat_a = d[3:0];
        if (a == 8'h06) m_lat_b = d;
    endtask

    task automatic dir_write(input logic s, input logic [7:0] w);
        dir_sel = s; work_reg = w; dir_load = 1'b1;
        @(negedge clk);
        dir_load = 1'b0;
        if (s) m_dir_b = w; else m_dir_a = w[3:0];
    endtask

    task automatic do_reset(input logic por);
        if (por) power_on_rst = 1'b1; else warm_rst = 1'b1;
        @(negedge clk);
        power_on_rst = 1'b0; warm_rst = 1'b0;
        m_dir_a = 4'hF; m_dir_b = 8'hFF;
        if (por) begin m_lat_a = 4'h5; m_lat_b = 8'hA5; end
    endtask

    // Drive pins, let the two synchronizer stages fill, then read both ports
    task automatic pin_read(input logic [3:0] pa, input logic [7:0] pb, input string req);
        pin_in_a = pa; pin_in_b = pb;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h05; #0.5;
        chk({req, " read narrow"}, bus_rd_data, {4'h0, pa});
        bus_addr = 8'h06; #0.5;
        chk({req, " read wide"}, bus_rd_data, pb);
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        power_on_rst = 1'b1; warm_rst = 1'b0; bus_wr = 1'b0; dir_load = 1'b0;
        dir_sel = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; work_reg = 8'h00;
        pin_in_a = 4'h0; pin_in_b = 8'h00;
        m_lat_a = 4'h5; m_lat_b = 8'hA5; m_dir_a = 4'hF; m_dir_b = 8'hFF;
        repeat (3) @(negedge clk);
        power_on_rst = 1'b0;

        // R2 R7: reset state
        chk_pads("R2 R7 power-on");

        // R3: bus writes do not alter direction
        bus_write(8'h05, 8'h00);
        bus_write(8'h06, 8'h00);
        chk_pads("R3 R5 bus write keeps dir");

        // R1 R3: direction loads
        dir_write(1'b0, 8'hF0);
        chk_pads("R1 R3 narrow dir load");
        dir_write(1'b1, 8'h0F);
        chk_pads("R1 R3 wide dir load");

        // R6: upper bits of narrow write discarded
        bus_write(8'h05, 8'hFA);
        chk_pads("R6 narrow write");

        // R4: driven high but held low reads 0
        bus_write(8'h06, 8'hFF);
        dir_write(1'b1, 8'h00);
        pin_read(4'h0, 8'h00, "R4 held low");

        // R9: other address reads 0
        pin_in_b = 8'hFF;
        repeat (2) @(negedge clk);
        bus_addr = 8'h07; #0.5;
        chk("R9 foreign read", bus_rd_data, 8'h00);

        // R8: warm reset keeps latch, forces inputs
        bus_write(8'h06, 8'h3C);
        do_reset(1'b0);
        chk_pads("R2 R8 warm reset");

        // R7: power-on reload
        bus_write(8'h06, 8'h11);
        do_reset(1'b1);
        chk_pads("R7 power-on reload");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                logic [7:0] a;
                a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (op[0] ? 8'h06 : 8'h05);
                bus_write(a, 8'($urandom));
                chk_pads("R5 R6 random write");
            end else if (op < 7) begin
                dir_write(1'($urandom), 8'($urandom));
                chk_pads("R1 R3 random dir");
            end else if (op < 9) begin
                pin_read(4'($urandom), 8'($urandom), "R4 random read");
            end else begin
                do_reset(1'($urandom_range(0, 3) == 0));
                chk_pads("R2 R7 R8 random reset");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule